// File: doc/BRIEF.md
# Two-Stage Undervoltage Trip Logic

This block turns undervoltage decisions made elsewhere into two protection outputs. Per-phase comparator flags, a ready-made inverse-time operate flag, per-stage mode and enable settings, external block and instantaneous-operate inputs, and per-phase flags for "below the blocking threshold" come in. A registered trip output (stage 1) and a registered alarm output (stage 2) go out. Stage 1 runs in one of three modes. When off it never trips. In definite-time mode it trips once any phase has stayed low for a configured number of clock cycles. In inverse-time mode it follows the external operate flag. Stage 2 always works as a definite-time alarm with its own delay.

A blocking veto applies when all three phases sit below the blocking threshold. The veto silences both stages and can itself be switched off. The block inputs and the veto take priority over the instantaneous and the timed paths. An instantaneous input skips the delay of its stage but cannot operate a stage that is switched off. Both delays are parameters given in clock cycles.

Top module: `uv_two_stage_trip`

## Requirements
- R1: `s1Mode` is decoded as 0 = off, 1 = definite time, 2 = inverse time, and 3 is treated as off. In off (0 or 3), `trip` stays low whatever the other stage 1 inputs do, including `s1Inst` and `s1InvOperate`.
- R2: In definite-time mode, with no instantaneous input, `trip` rises at the clock edge that closes the S1_DELAY-th consecutive cycle in which at least one bit of `s1PhaseLow` is set. A cycle with no bit set restarts the count.
- R3: In definite-time mode, `trip` falls at the first clock edge that samples `s1PhaseLow` all zero, provided `s1Inst` is low at that edge.
- R4: In inverse-time mode, `trip` one cycle later equals `s1InvOperate`. `s1PhaseLow` has no effect in this mode.
- R5: While `s1Block` is high, `trip` is low one cycle later, even if `s1Inst` or `s1InvOperate` is high.
- R6: In definite-time or inverse-time mode, with no block and no veto, `s1Inst` high sets `trip` one cycle later with no delay.
- R7: With stage 2 enabled and no block or veto, `alarm` rises at the edge that closes the S2_DELAY-th consecutive cycle in which at least one bit of `s2PhaseLow` is set. It falls at the first edge that samples them all zero while `s2Inst` is low.
- R8: When `s2Enable` is low or `s2Block` is high, `alarm` is low one cycle later, even if `s2Inst` is high.
- R9: With stage 2 enabled and no block or veto, `s2Inst` high sets `alarm` one cycle later.
- R10: When `vetoEnable` is high and all three bits of `vetoLow` are set, both `trip` and `alarm` are low one cycle later, even with instantaneous inputs high. Both delay counts restart.
- R11: When `vetoEnable` is low, or when any bit of `vetoLow` is clear, `vetoLow` has no effect on either output.
- R12: An active-low `rstN` forces `trip` and `alarm` low at once and clears both delay counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| s1Mode | input | 2 | Stage 1 mode: 0 off, 1 definite time, 2 inverse time, 3 off |
| s1Block | input | 1 | Stage 1 external block |
| s1Inst | input | 1 | Stage 1 instantaneous trip request |
| s1PhaseLow | input | 3 | Stage 1 per-phase undervoltage flags |
| s1InvOperate | input | 1 | Inverse-time operate flag from the curve logic |
| s2Enable | input | 1 | Stage 2 enable switch |
| s2Block | input | 1 | Stage 2 external block |
| s2Inst | input | 1 | Stage 2 instantaneous alarm request |
| s2PhaseLow | input | 3 | Stage 2 per-phase undervoltage flags |
| vetoLow | input | 3 | Per-phase flags, below the blocking threshold |
| vetoEnable | input | 1 | Enable for the all-phase blocking veto |
| trip | output | 1 | Stage 1 trip, registered |
| alarm | output | 1 | Stage 2 alarm, registered |

## Verification
The only hidden state is the two delay counters. A counter that fails to clear on a gap, on a veto or on reset shows up as a trip or alarm that arrives too early. This can be seen within one delay period after the condition returns. A counter that stalls or saturates too low shows as an output that is late or never rises. Sampling the output on every cycle of a held condition pins the edge exactly. The mode, block and veto gating carries no state, so a wrong gate appears on the output one cycle after the offending input pattern.

// File: rtl/uvt_pkg.sv
package uvt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DT   = 2'd1,
    MODE_IDMT = 2'd2,
    MODE_RSVD = 2'd3
  } uvMode_e;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic run1;   // stage 1 timer may count this cycle
    logic fast1;  // stage 1 operates without the timer
    logic run2;   // stage 2 timer may count this cycle
    logic fast2;  // stage 2 operates without the timer
  } uvStrobes_t;

endpackage

// File: rtl/uvt_pickup_timer.sv
module uvt_pickup_timer #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic done
);

  localparam int CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DELAY - 1);

  logic [CNT_W-1:0] cnt;

  // cnt holds the number of consecutive earlier cycles with run high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt < LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt >= LAST);

endmodule

// File: rtl/uvt_ctrl.sv
module uvt_ctrl
  import uvt_pkg::*;
(
  input  logic       [1:0] s1Mode,
  input  logic             s1Block,
  input  logic             s1Inst,
  input  logic       [2:0] s1PhaseLow,
  input  logic             s1InvOperate,
  input  logic             s2Enable,
  input  logic             s2Block,
  input  logic             s2Inst,
  input  logic       [2:0] s2PhaseLow,
  input  logic       [2:0] vetoLow,
  input  logic             vetoEnable,
  output uvStrobes_t       strobes
);

  uvMode_e mode;
  logic    veto;
  logic    s1Live;
  logic    s2Live;

  always_comb begin
    mode   = uvMode_e'(s1Mode);
    veto   = vetoEnable && (&vetoLow);
    s1Live = ((mode == MODE_DT) || (mode == MODE_IDMT)) && !s1Block && !veto;
    s2Live = s2Enable && !s2Block && !veto;

    strobes.run1  = s1Live && (mode == MODE_DT) && (|s1PhaseLow);
    strobes.fast1 = s1Live && (s1Inst || ((mode == MODE_IDMT) && s1InvOperate));
    strobes.run2  = s2Live && (|s2PhaseLow);
    strobes.fast2 = s2Live && s2Inst;
  end

endmodule

// File: rtl/uvt_datapath.sv
module uvt_datapath
  import uvt_pkg::*;
#(
  parameter int S1_DELAY = 8,
  parameter int S2_DELAY = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  uvStrobes_t strobes,
  output logic       trip,
  output logic       alarm
);

  logic done1;
  logic done2;

  uvt_pickup_timer #(.DELAY(S1_DELAY)) u_timer1 (
    .clk  (clk),
    .rstN (rstN),
    .run  (strobes.run1),
    .done (done1)
  );

  uvt_pickup_timer #(.DELAY(S2_DELAY)) u_timer2 (
    .clk  (clk),
    .rstN (rstN),
    .run  (strobes.run2),
    .done (done2)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trip  <= 1'b0;
      alarm <= 1'b0;
    end else begin
      trip  <= strobes.fast1 || done1;
      alarm <= strobes.fast2 || done2;
    end
  end

endmodule

// File: rtl/uv_two_stage_trip.sv
module uv_two_stage_trip
  import uvt_pkg::*;
#(
  parameter int S1_DELAY = 8,
  parameter int S2_DELAY = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] s1Mode,
  input  logic       s1Block,
  input  logic       s1Inst,
  input  logic [2:0] s1PhaseLow,
  input  logic       s1InvOperate,
  input  logic       s2Enable,
  input  logic       s2Block,
  input  logic       s2Inst,
  input  logic [2:0] s2PhaseLow,
  input  logic [2:0] vetoLow,
  input  logic       vetoEnable,
  output logic       trip,
  output logic       alarm
);

  uvStrobes_t strobes;

  uvt_ctrl u_ctrl (
    .s1Mode       (s1Mode),
    .s1Block      (s1Block),
    .s1Inst       (s1Inst),
    .s1PhaseLow   (s1PhaseLow),
    .s1InvOperate (s1InvOperate),
    .s2Enable     (s2Enable),
    .s2Block      (s2Block),
    .s2Inst       (s2Inst),
    .s2PhaseLow   (s2PhaseLow),
    .vetoLow      (vetoLow),
    .vetoEnable   (vetoEnable),
    .strobes      (strobes)
  );

  uvt_datapath #(
    .S1_DELAY (S1_DELAY),
    .S2_DELAY (S2_DELAY)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .trip    (trip),
    .alarm   (alarm)
  );

endmodule

// File: rtl/uvt_checker.sv
module uvt_checker #(
  parameter int S1_DELAY = 8,
  parameter int S2_DELAY = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] s1Mode,
  input logic       s1Block,
  input logic       s1Inst,
  input logic [2:0] s1PhaseLow,
  input logic       s1InvOperate,
  input logic       s2Enable,
  input logic       s2Block,
  input logic       s2Inst,
  input logic [2:0] s2PhaseLow,
  input logic [2:0] vetoLow,
  input logic       vetoEnable,
  input logic       trip,
  input logic       alarm
);

  logic vetoOn;
  logic modeOff;
  logic dtQual;
  logic s2Qual;
  int   runLen1;
  int   runLen2;

  assign vetoOn  = vetoEnable && (vetoLow == 3'b111);
  assign modeOff = (s1Mode == 2'd0) || (s1Mode == 2'd3);
  assign dtQual  = (s1Mode == 2'd1) && !s1Block && !vetoOn && (s1PhaseLow != 3'b000);
  assign s2Qual  = s2Enable && !s2Block && !vetoOn && (s2PhaseLow != 3'b000);

  // consecutive qualified cycles seen before the current one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen1 <= 0;
      runLen2 <= 0;
    end else begin
      runLen1 <= dtQual ? ((runLen1 < S1_DELAY) ? runLen1 + 1 : runLen1) : 0;
      runLen2 <= s2Qual ? ((runLen2 < S2_DELAY) ? runLen2 + 1 : runLen2) : 0;
    end
  end

  assert_off_mode_R1: assert property (@(posedge clk) disable iff (!rstN)
    modeOff |=> !trip);

  assert_dt_early_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dtQual && !s1Inst && (runLen1 < S1_DELAY - 1)) |=> !trip);

  assert_dt_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((s1Mode == 2'd1) && !s1Inst && (s1PhaseLow == 3'b000)) |=> !trip);

  assert_idmt_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((s1Mode == 2'd2) && !s1Block && !vetoOn && !s1Inst) |=> (trip == $past(s1InvOperate)));

  assert_block1_R5: assert property (@(posedge clk) disable iff (!rstN)
    s1Block |=> !trip);

  assert_inst1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (s1Inst && !modeOff && !s1Block && !vetoOn) |=> trip);

  assert_dt2_early_R7: assert property (@(posedge clk) disable iff (!rstN)
    (s2Qual && !s2Inst && (runLen2 < S2_DELAY - 1)) |=> !alarm);

  assert_block2_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!s2Enable || s2Block) |=> !alarm);

  assert_inst2_R9: assert property (@(posedge clk) disable iff (!rstN)
    (s2Inst && s2Enable && !s2Block && !vetoOn) |=> alarm);

  assert_veto_R10: assert property (@(posedge clk) disable iff (!rstN)
    vetoOn |=> (!trip && !alarm));

endmodule

bind uv_two_stage_trip uvt_checker #(
  .S1_DELAY (S1_DELAY),
  .S2_DELAY (S2_DELAY)
) u_uvt_checker (
  .clk          (clk),
  .rstN         (rstN),
  .s1Mode       (s1Mode),
  .s1Block      (s1Block),
  .s1Inst       (s1Inst),
  .s1PhaseLow   (s1PhaseLow),
  .s1InvOperate (s1InvOperate),
  .s2Enable     (s2Enable),
  .s2Block      (s2Block),
  .s2Inst       (s2Inst),
  .s2PhaseLow   (s2PhaseLow),
  .vetoLow      (vetoLow),
  .vetoEnable   (vetoEnable),
  .trip         (trip),
  .alarm        (alarm)
);

// File: tb/uv_two_stage_trip_bench.sv
`timescale 1ns/1ps
module uv_two_stage_trip_bench;

  localparam int D1 = 5;
  localparam int D2 = 3;
  localparam int NVEC = 14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] s1Mode = 2'd0;
  logic       s1Block = 1'b0;
  logic       s1Inst = 1'b0;
  logic [2:0] s1PhaseLow = 3'b000;
  logic       s1InvOperate = 1'b0;
  logic       s2Enable = 1'b0;
  logic       s2Block = 1'b0;
  logic       s2Inst = 1'b0;
  logic [2:0] s2PhaseLow = 3'b000;
  logic [2:0] vetoLow = 3'b000;
  logic       vetoEnable = 1'b0;
  logic       trip;
  logic       alarm;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uv_two_stage_trip #(.S1_DELAY(D1), .S2_DELAY(D2)) u_uv_two_stage_trip (
    .clk(clk), .rstN(rstN), .s1Mode(s1Mode), .s1Block(s1Block), .s1Inst(s1Inst),
    .s1PhaseLow(s1PhaseLow), .s1InvOperate(s1InvOperate), .s2Enable(s2Enable),
    .s2Block(s2Block), .s2Inst(s2Inst), .s2PhaseLow(s2PhaseLow),
    .vetoLow(vetoLow), .vetoEnable(vetoEnable), .trip(trip), .alarm(alarm)
  );

  // {mode[13:12], blk1, inst1, inv1, en2, blk2, inst2, vetoLow[5:3], vetoEn, expTrip, expAlarm}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b01_0_1_0_1_0_0_000_0_1_0,  // R6 DT instantaneous
    14'b10_0_1_0_0_0_0_000_0_1_0,  // R6 IDMT instantaneous
    14'b00_0_1_1_0_0_0_000_0_0_0,  // R1 off ignores inst and inv
    14'b11_0_1_1_0_0_0_000_0_0_0,  // R1 code 3 acts as off
    14'b10_0_0_1_0_0_0_000_0_1_0,  // R4 IDMT operate
    14'b10_0_0_0_0_0_0_000_0_0_0,  // R4 IDMT idle
    14'b10_1_1_1_0_0_0_000_0_0_0,  // R5 block beats inst
    14'b00_0_0_0_1_0_1_000_0_0_1,  // R9 alarm inst
    14'b00_0_0_0_0_0_1_000_0_0_0,  // R8 disabled stage 2
    14'b00_0_0_0_1_1_1_000_0_0_0,  // R8 blocked stage 2
    14'b10_0_1_1_1_0_1_111_1_0_0,  // R10 veto beats both
    14'b10_0_1_1_1_0_1_110_1_1_1,  // R11 partial low
    14'b10_0_1_1_1_0_1_111_0_1_1,  // R11 veto switched off
    14'b01_0_1_0_1_0_1_000_0_1_1   // R6 both stages at once
  };

  function automatic string tagOf(int i);
    case (i)
      0, 1, 13: return "R6";
      2, 3:     return "R1";
      4, 5:     return "R4";
      6:        return "R5";
      7:        return "R9";
      8, 9:     return "R8";
      10:       return "R10";
      default:  return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    s1Mode = 2'd0; s1Block = 1'b0; s1Inst = 1'b0; s1PhaseLow = 3'b000;
    s1InvOperate = 1'b0; s2Enable = 1'b0; s2Block = 1'b0; s2Inst = 1'b0;
    s2PhaseLow = 3'b000; vetoLow = 3'b000; vetoEnable = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12 reset holds outputs low even with instantaneous inputs active
    s1Mode = 2'd1; s1Inst = 1'b1; s2Enable = 1'b1; s2Inst = 1'b1;
    cyc(); cyc(); cyc();
    chk("R12", "trip in reset", trip, 1'b0);
    chk("R12", "alarm in reset", alarm, 1'b0);
    idle();
    rstN = 1'b1;
    cyc();
    chk("R12", "trip after reset idle", trip, 1'b0);

    // table of combinational-path vectors (no phase flags, timers idle)
    for (int i = 0; i < NVEC; i++) begin
      logic [13:0] v;
      v = VEC[i];
      s1Mode = v[13:12]; s1Block = v[11]; s1Inst = v[10]; s1InvOperate = v[9];
      s2Enable = v[8]; s2Block = v[7]; s2Inst = v[6];
      vetoLow = v[5:3]; vetoEnable = v[2];
      cyc();
      chk(tagOf(i), "trip vector", trip, v[1]);
      chk(tagOf(i), "alarm vector", alarm, v[0]);
    end
    idle();
    cyc();

    // R2 definite-time pick-up edge
    s1Mode = 2'd1; s1PhaseLow = 3'b010;
    for (int k = 1; k <= D1 + 1; k++) begin
      cyc();
      chk("R2", "trip during pick-up", trip, (k >= D1));
    end
    // R3 release on the first clear sample
    s1PhaseLow = 3'b000;
    cyc();
    chk("R3", "trip release", trip, 1'b0);

    // R2 a gap restarts the count
    s1PhaseLow = 3'b001;
    for (int k = 1; k < D1; k++) cyc();
    s1PhaseLow = 3'b000;
    cyc();
    s1PhaseLow = 3'b100;
    for (int k = 1; k < D1; k++) begin
      cyc();
      chk("R2", "trip after gap", trip, 1'b0);
    end
    cyc();
    chk("R2", "trip after full run", trip, 1'b1);
    idle();
    cyc();

    // R4 phase flags ignored in inverse-time mode
    s1Mode = 2'd2; s1PhaseLow = 3'b111;
    for (int k = 0; k < D1 + 2; k++) cyc();
    chk("R4", "phase flags in IDMT", trip, 1'b0);
    idle();
    cyc();

    // R10 veto in the middle of the pick-up restarts the count
    s1Mode = 2'd1; s1PhaseLow = 3'b001;
    for (int k = 0; k < D1 - 1; k++) cyc();
    vetoEnable = 1'b1; vetoLow = 3'b111;
    cyc();
    chk("R10", "trip under veto", trip, 1'b0);
    vetoEnable = 1'b0;
    for (int k = 1; k < D1; k++) begin
      cyc();
      chk("R10", "trip after veto restart", trip, 1'b0);
    end
    cyc();
    chk("R10", "trip after veto full run", trip, 1'b1);

    // R12 asynchronous reset drops a live trip and clears the count
    rstN = 1'b0;
    #1;
    chk("R12", "trip on async reset", trip, 1'b0);
    cyc();
    rstN = 1'b1;
    for (int k = 1; k < D1; k++) begin
      cyc();
      chk("R12", "trip after reset restart", trip, 1'b0);
    end
    cyc();
    chk("R12", "trip after reset full run", trip, 1'b1);
    idle();
    cyc();

    // R7 stage 2 pick-up and release
    s2Enable = 1'b1; s2PhaseLow = 3'b100;
    for (int k = 1; k <= D2 + 1; k++) begin
      cyc();
      chk("R7", "alarm during pick-up", alarm, (k >= D2));
    end
    s2PhaseLow = 3'b000;
    cyc();
    chk("R7", "alarm release", alarm, 1'b0);

    // R8 block during a held condition
    s2PhaseLow = 3'b011;
    for (int k = 0; k < D2; k++) cyc();
    s2Block = 1'b1;
    cyc();
    chk("R8", "alarm blocked while timed", alarm, 1'b0);
    idle();
    cyc();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule